// File: doc/BRIEF.md
# Predicated widening vector load unit

This unit carries out one contiguous vector load under a lane mask. On a start strobe it takes a base byte address, a small signed multiplier that moves the base by whole vector lengths, and one enable bit per destination lane. Each destination lane is 32 bits wide. For every enabled lane the unit reads one 16-bit halfword from memory and places it, zero-extended, in that lane. Disabled lanes are written as zero. They never produce a memory access and never produce a fault.

Memory is reached through a simple port with one request in flight at a time. The unit raises a single-cycle request with an address. The memory answers later with a valid strobe, the data and an error bit. Enabled lanes are visited from lane 0 upward. The first error response ends the operation and reports the lane that failed. The assembled vector, the fault flag and the fault lane hold from the done pulse until the next start. A start is accepted only while the unit is idle. The vector width is a parameter from 128 to 2048 bits, and the unit behaves the same at every width.

Top module: `vld_widen_unit`

## Requirements
- R1: The vector holds VLEN/32 lanes. Lane i occupies bits [32i+31:32i] of vec_o and is read from byte address eff + 2*i.
- R2: Bits [31:16] of every lane of vec_o are zero after every operation. Bits [15:0] of a loaded lane equal the returned halfword.
- R3: A request is issued only for lanes whose predicate bit is 1. Requests go in ascending lane order. mem_req_o is high for exactly one cycle per request, and the next request waits until the previous response has arrived.
- R4: fault_o is set only by an error response to a request. fault_lane_o then names an enabled lane. A disabled lane whose address would return an error causes no fault.
- R5: Every disabled lane reads as zero in vec_o after done, even when the previous operation left that lane nonzero.
- R6: eff = base_i + sext(imm_i) * (VLEN/16), computed modulo 2^ADDR_W. imm_i is a 4-bit two's complement value in the range -8 to 7.
- R7: On the first response with mem_err_i = 1, no further request is issued. fault_o = 1 and fault_lane_o holds that lane's index. Enabled lanes loaded before it hold their data, and that lane and all later lanes read as zero.
- R8: done_o is a one-cycle pulse. It is high in the cycle after the final response is accepted.
- R9: With an all-zero predicate, done_o is high in the cycle right after the start edge. vec_o is then zero, fault_o is 0 and no request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts an operation when the unit is idle |
| base_i | input | ADDR_W | Base byte address |
| imm_i | input | 4 | Signed vector-length multiplier |
| pred_i | input | VLEN/32 | Lane enable mask |
| mem_req_o | output | 1 | Halfword read request strobe |
| mem_addr_o | output | ADDR_W | Request byte address |
| mem_rvalid_i | input | 1 | Response valid |
| mem_rdata_i | input | 16 | Response halfword |
| mem_err_i | input | 1 | Response carries an error |
| done_o | output | 1 | Operation complete pulse |
| fault_o | output | 1 | Operation stopped on an error |
| fault_lane_o | output | log2(VLEN/32) | Lane index of the error |
| vec_o | output | VLEN | Assembled destination vector |

## Verification
The bench places an error address under a disabled lane. A design that checked for errors without looking at the mask would then report a false fault or issue a stray request. It runs operations back to back with masks that differ. This catches a result register that is not cleared between operations, which would leave stale data in disabled lanes. Injected errors on the first and last enabled lanes check that the unit stops at once and keeps only the lanes loaded before the error. The imm_i extremes -8 and 7 catch a multiplier that is not sign-extended, or that scales by the wrong vector size. The all-zero mask catches a design that is one cycle late or that issues a request anyway.

// File: rtl/vld_pkg.sv
package vld_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_DONE} vld_state_e;
endpackage

// File: rtl/vld_addr_gen.sv
module vld_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 4,
  parameter int LANES  = 4,
  parameter int LANE_W = 2
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [ADDR_W-1:0] eff_i,
  input  logic [LANE_W-1:0] lane_i,
  output logic [ADDR_W-1:0] eff_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int VBYTES = LANES * 2;
  logic [ADDR_W-1:0] imm_ext;
  assign imm_ext = {{(ADDR_W-IMM_W){imm_i[IMM_W-1]}}, imm_i};
  // wraps modulo 2^ADDR_W, so negative offsets come out right
  assign eff_o  = base_i + imm_ext * ADDR_W'(VBYTES);
  assign addr_o = eff_i + {{(ADDR_W-LANE_W-1){1'b0}}, lane_i, 1'b0};
endmodule

// File: rtl/vld_lane_pick.sv
module vld_lane_pick #(
  parameter int LANES  = 4,
  parameter int LANE_W = 2
) (
  input  logic [LANES-1:0]  mask_i,
  output logic              any_o,
  output logic [LANE_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (mask_i[i]) idx_o = LANE_W'(i);
    end
  end
  assign any_o = |mask_i;
endmodule

// File: rtl/vld_lane_buf.sv
module vld_lane_buf #(
  parameter int LANES  = 4,
  parameter int LANE_W = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               wr_i,
  input  logic [LANE_W-1:0]  idx_i,
  input  logic [15:0]        data_i,
  output logic [LANES*32-1:0] vec_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [15:0] half_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) half_q <= '0;
      else if (clr_i) half_q <= '0;
      else if (wr_i && idx_i == LANE_W'(g)) half_q <= data_i;
    end
    assign vec_o[32*g +: 32] = {16'h0000, half_q};
  end
endmodule

// File: rtl/vld_widen_unit.sv
module vld_widen_unit #(
  parameter int VLEN   = 128,
  parameter int ADDR_W = 32,
  localparam int LANES  = VLEN / 32,
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [3:0]        imm_i,
  input  logic [LANES-1:0]  pred_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [15:0]       mem_rdata_i,
  input  logic              mem_err_i,
  output logic              done_o,
  output logic              fault_o,
  output logic [LANE_W-1:0] fault_lane_o,
  output logic [VLEN-1:0]   vec_o
);
  import vld_pkg::*;

  vld_state_e        state_q;
  logic [LANES-1:0]  pred_q, pend_q, pend_left;
  logic [ADDR_W-1:0] eff_q, eff_new;
  logic [LANE_W-1:0] cur_q, pick_idx;
  logic              pick_any, accept, rsp_ok;

  assign accept = (state_q == ST_IDLE) && start_i;
  assign rsp_ok = (state_q == ST_WAIT) && mem_rvalid_i && !mem_err_i;

  vld_addr_gen #(.ADDR_W(ADDR_W), .IMM_W(4), .LANES(LANES), .LANE_W(LANE_W)) u_addr (
    .base_i(base_i), .imm_i(imm_i), .eff_i(eff_q), .lane_i(pick_idx),
    .eff_o(eff_new), .addr_o(mem_addr_o)
  );

  vld_lane_pick #(.LANES(LANES), .LANE_W(LANE_W)) u_pick (
    .mask_i(pend_q), .any_o(pick_any), .idx_o(pick_idx)
  );

  vld_lane_buf #(.LANES(LANES), .LANE_W(LANE_W)) u_buf (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(accept), .wr_i(rsp_ok),
    .idx_i(cur_q), .data_i(mem_rdata_i), .vec_o(vec_o)
  );

  always_comb begin
    pend_left = pend_q;
    pend_left[cur_q] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      pred_q       <= '0;
      pend_q       <= '0;
      eff_q        <= '0;
      cur_q        <= '0;
      fault_o      <= 1'b0;
      fault_lane_o <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          pred_q       <= pred_i;
          pend_q       <= pred_i;
          eff_q        <= eff_new;
          fault_o      <= 1'b0;
          fault_lane_o <= '0;
          state_q      <= (|pred_i) ? ST_ISSUE : ST_DONE;
        end
        ST_ISSUE: begin
          cur_q   <= pick_idx;
          state_q <= ST_WAIT;
        end
        ST_WAIT: if (mem_rvalid_i) begin
          if (mem_err_i) begin
            fault_o      <= 1'b1;
            fault_lane_o <= cur_q;
            pend_q       <= '0;
            state_q      <= ST_DONE;
          end else begin
            pend_q  <= pend_left;
            state_q <= (|pend_left) ? ST_ISSUE : ST_DONE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_o = (state_q == ST_ISSUE) && pick_any;
  assign done_o    = (state_q == ST_DONE);

  function automatic logic dead_lane_dirty(logic [VLEN-1:0] v, logic [LANES-1:0] p);
    logic r;
    r = 1'b0;
    for (int i = 0; i < LANES; i++) if (!p[i] && v[32*i +: 32] != '0) r = 1'b1;
    return r;
  endfunction

  p_req_active_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> pred_q[pick_idx]);
  p_one_req_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);
  p_fault_active_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_o) |-> pred_q[fault_lane_o]);
  p_dead_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !dead_lane_dirty(vec_o, pred_q));
  p_fault_stop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && mem_rvalid_i && mem_err_i) |=> (done_o && fault_o && !mem_req_o));
  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_empty_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && pred_i == '0) |=> (done_o && !fault_o));
endmodule

// File: tb/vld_widen_unit_tb.sv
module vld_widen_unit_tb;
  localparam int VLEN   = 256;
  localparam int ADDR_W = 32;
  localparam int LANES  = VLEN / 32;
  localparam int LANE_W = $clog2(LANES);

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0;
  logic [ADDR_W-1:0] base = '0;
  logic [3:0] imm = '0;
  logic [LANES-1:0] pred = '0;
  logic req;
  logic [ADDR_W-1:0] addr;
  logic rvalid = 1'b0, err = 1'b0;
  logic [15:0] rdata = '0;
  logic done, fault;
  logic [LANE_W-1:0] flane;
  logic [VLEN-1:0] vec;

  int checks = 0, fails = 0;
  logic [ADDR_W-1:0] cur_eff = '0, err_addr = '0;
  logic err_en = 1'b0;
  int req_cnt = 0, last_lane = -1, bad_req = 0;
  int lat_max = 2;

  always #5 clk = ~clk;

  vld_widen_unit #(.VLEN(VLEN), .ADDR_W(ADDR_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .base_i(base), .imm_i(imm),
    .pred_i(pred), .mem_req_o(req), .mem_addr_o(addr), .mem_rvalid_i(rvalid),
    .mem_rdata_i(rdata), .mem_err_i(err), .done_o(done), .fault_o(fault),
    .fault_lane_o(flane), .vec_o(vec)
  );

  function automatic logic [15:0] mem_word(logic [ADDR_W-1:0] a);
    return a[15:0] ^ {a[23:16], a[31:24]} ^ 16'h9e37;
  endfunction

  function automatic logic [ADDR_W-1:0] eff_of(logic [ADDR_W-1:0] b, logic [3:0] i);
    logic signed [ADDR_W-1:0] s;
    s = ADDR_W'($signed(i));
    return b + ADDR_W'(s * (VLEN / 16));
  endfunction

  task automatic check(input logic ok, input string tag, input logic [VLEN-1:0] act,
                       input logic [VLEN-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // memory model: one response per request after a random latency
  initial begin
    forever begin
      @(negedge clk);
      rvalid = 1'b0;
      err = 1'b0;
      if (req) begin
        automatic logic [ADDR_W-1:0] a = addr;
        automatic logic [ADDR_W-1:0] d = a - cur_eff;
        automatic int ln = int'(d >> 1);
        automatic int lat = $urandom_range(lat_max, 0);
        req_cnt++;
        if (d[0] || d >= ADDR_W'(2 * LANES) || !pred[ln] || ln <= last_lane) bad_req++;
        last_lane = ln;
        repeat (lat) @(negedge clk);
        @(negedge clk);
        rvalid = 1'b1;
        rdata = mem_word(a);
        err = err_en && (a == err_addr);
      end
    end
  end

  task automatic run_op(input logic [ADDR_W-1:0] b, input logic [3:0] i,
                        input logic [LANES-1:0] p, input logic e_en, input int e_lane);
    logic [VLEN-1:0] exp_vec;
    logic exp_fault;
    int exp_lane, exp_reqs, cyc;
    cur_eff = eff_of(b, i);
    err_en = e_en;
    err_addr = cur_eff + ADDR_W'(2 * e_lane);
    exp_vec = '0; exp_fault = 1'b0; exp_lane = 0; exp_reqs = 0;
    for (int k = 0; k < LANES; k++) begin
      if (p[k] && !exp_fault) begin
        exp_reqs++;
        if (e_en && k == e_lane) begin
          exp_fault = 1'b1;
          exp_lane = k;
        end else exp_vec[32*k +: 32] = {16'h0, mem_word(cur_eff + ADDR_W'(2 * k))};
      end
    end
    req_cnt = 0; last_lane = -1; bad_req = 0;
    @(negedge clk);
    base = b; imm = i; pred = p; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
    check(done, "R8 done seen", VLEN'(done), VLEN'(1));
    if (p == '0) check(cyc == 1, "R9 empty done latency", VLEN'(cyc), VLEN'(1));
    check(vec == exp_vec, "R1/R2/R5/R6 vector", vec, exp_vec);
    check(fault == exp_fault, "R4/R7 fault flag", VLEN'(fault), VLEN'(exp_fault));
    if (exp_fault) check(int'(flane) == exp_lane, "R7 fault lane", VLEN'(flane), VLEN'(exp_lane));
    @(negedge clk);
    check(!done, "R8 done one cycle", VLEN'(done), VLEN'(0));
    check(req_cnt == exp_reqs && bad_req == 0, "R3 request set",
          VLEN'(req_cnt * 256 + bad_req), VLEN'(exp_reqs * 256));
  endtask

  initial begin
    #(10 * 200000);
    fails++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check(!done && !req && !fault && vec == '0, "reset state", vec, '0);
    rst_n = 1'b1;
    // R9: empty mask, imm extremes for R6
    run_op(32'h0000_1000, 4'h0, '0, 1'b0, 0);
    run_op(32'h0000_1000, 4'h7, '1, 1'b0, 0);
    run_op(32'h0000_1000, 4'h8, '1, 1'b0, 0);
    // R5: previous op filled all lanes, now sparse mask
    run_op(32'h0000_2000, 4'hf, 8'b1010_0101, 1'b0, 0);
    // R4: error under a disabled lane
    run_op(32'h0000_3000, 4'h1, 8'b1111_1101, 1'b1, 1);
    // R7: error on first and last enabled lanes
    run_op(32'h0000_4000, 4'h2, 8'b0110_1100, 1'b1, 2);
    run_op(32'h0000_4000, 4'h2, 8'b0110_1100, 1'b1, 6);
    run_op(32'hffff_fff0, 4'h3, '1, 1'b0, 0);
    for (int n = 0; n < 200; n++) begin
      automatic logic [LANES-1:0] p = LANES'($urandom);
      automatic logic [3:0] i = 4'($urandom);
      automatic logic [ADDR_W-1:0] b = {$urandom} & 32'hffff_fffe;
      lat_max = $urandom_range(3, 0);
      run_op(b, i, p, ($urandom_range(1, 0) == 1), $urandom_range(LANES - 1, 0));
    end
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule